// File: doc/BRIEF.md
# BCD Calendar Clock with Digit-Masked Alarm

This block keeps the time of day and the calendar date as packed BCD digits. A one-cycle `sec_tick` pulse advances the clock by one second. Seconds carry into minutes, minutes into hours, and hours into the day. The day carries into the month and the month into a two-digit year. A day-of-week counter moves on every day carry, and a leap-year indication follows the year digits. The hours run in either a 24-hour or a 12-hour format. In 12-hour format an AM/PM bit rides in the top bit of the tens-of-hours field.

A host loads the time, date, weekday, format and alarm settings through a simple write port. Each write is an address, a data word and a strobe. The alarm compares the running time and date digit by digit against alarm words, and any digit can be masked out of the comparison. The comparison is made in the cycle after each second update. When every unmasked digit agrees, the alarm flag is set. The interrupt output is the flag gated by an enable. The host clears the flag by writing 1 to a clear address.

Top module: `rtc_calendar`

## Requirements
- R1: Time word layout is hour tens [21:20], hour units [19:16], minute tens [14:12], minute units [11:8], second tens [6:4] and second units [3:0]. Bits 15 and 7 read 0. On each `sec_tick` the seconds advance in BCD. Second units wrap 9 to 0 and carry into second tens. Second tens wrap 5 to 0 and carry into the minutes. The minutes count the same way and carry into the hours. The new value is visible on the cycle after the tick.
- R2: In a cycle with neither `sec_tick` nor a write, `time_o` and `date_o` keep their values.
- R3: In 24-hour format (mode bit 1) the hours count 00 to 23. The step from 23 to 00 produces a day carry.
- R4: In 12-hour format (mode bit 0), bit 21 is the PM indicator (1 = PM) and bit 20 is the hour tens digit. The hours count 12, 01, ..., 11. The step from 11 to 12 toggles PM. The step from 11 PM to 12 AM produces a day carry.
- R5: Date word layout is year tens [23:20], year units [19:16], month tens [12], month units [11:8], day tens [5:4] and day units [3:0]. On a day carry the day advances in BCD. Past the last day of the month the day becomes 01 and the month advances. Past month 12 the month becomes 01 and the year advances, with 99 wrapping to 00. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days in a leap year and 28 otherwise. All other months have 31 days.
- R6: `leap_o` is 1 exactly when the two-digit BCD year is divisible by 4.
- R7: `weekday_o` (0 = Sunday to 6 = Saturday) advances by one on each day carry. Both 6 and the reserved value 7 step to 0. The weekday is never checked against the date.
- R8: Time mask bits 0 to 5 exclude second units, second tens, minute units, minute tens, hour units and hour tens. Date mask bits 0 to 5 exclude day units, day tens, month units, month tens, year units and year tens. A comparison is made in the cycle after each `sec_tick`. When every unmasked digit equals its alarm digit, `alarm_flag_o` is 1 from the next cycle on.
- R9: The two hour mask bits take effect only in 24-hour format. In 12-hour format both hour fields, including the PM bit, are always compared.
- R10: `irq_o` is `alarm_flag_o` AND the alarm enable (bit 0 at address 8). Writing a data word with bit 0 set to address 9 clears the flag. A match in the same cycle wins over the clear.
- R11: Write addresses are: 0 time, 1 date, 2 weekday [2:0], 3 mode [0], 4 alarm time, 5 alarm date, 6 time mask [5:0], 7 date mask [5:0], 8 alarm enable [0], 9 flag clear [0]. After reset the block holds time 00:00:00 in 24-hour format and date 00-01-01 with weekday 6. The flag, the masks, the alarm words and the enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 24 | Host write data |
| time_o | output | 22 | Current time word |
| date_o | output | 24 | Current date word |
| weekday_o | output | 3 | Current day of week |
| leap_o | output | 1 | Current year is a leap year |
| alarm_flag_o | output | 1 | Alarm match flag |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The counters feed each other through carries. A wrong digit or a lost carry therefore shows at `time_o` on the cycle after the tick that should have moved it. It spreads into `date_o` and `weekday_o` only at the next midnight, so the bench forces each rollover by loading the time just before it. A faulty month-length or leap decode stays hidden until the last day of that month. For this reason every month is rolled over in both a leap and a non-leap year. A mask or compare fault shows on `alarm_flag_o` exactly two cycles after a tick. That is too early, too late, a missing set or a repeated set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int TIME_W = 22;
    localparam int DATE_W = 24;
    localparam int WORD_W = 24;
    localparam int ADDR_W = 4;
    localparam int WDAY_W = 3;
    localparam int DIG_N  = 6;

    localparam logic [ADDR_W-1:0] A_TIME  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DATE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_WDAY  = 4'd2;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'd3;
    localparam logic [ADDR_W-1:0] A_ATIME = 4'd4;
    localparam logic [ADDR_W-1:0] A_ADATE = 4'd5;
    localparam logic [ADDR_W-1:0] A_TMASK = 4'd6;
    localparam logic [ADDR_W-1:0] A_DMASK = 4'd7;
    localparam logic [ADDR_W-1:0] A_AEN   = 4'd8;
    localparam logic [ADDR_W-1:0] A_ACLR  = 4'd9;

    localparam logic [WDAY_W-1:0] WD_RESET = 3'd6;

    typedef struct packed {
        logic [1:0] hr_t;
        logic [3:0] hr_u;
        logic [2:0] mn_t;
        logic [3:0] mn_u;
        logic [2:0] sc_t;
        logic [3:0] sc_u;
    } clk_time_s;

    typedef struct packed {
        logic [3:0] yr_t;
        logic [3:0] yr_u;
        logic       mo_t;
        logic [3:0] mo_u;
        logic [1:0] dy_t;
        logic [3:0] dy_u;
    } clk_date_s;

    function automatic clk_time_s time_from_word(input logic [WORD_W-1:0] w);
        clk_time_s t;
        t.hr_t = w[21:20];
        t.hr_u = w[19:16];
        t.mn_t = w[14:12];
        t.mn_u = w[11:8];
        t.sc_t = w[6:4];
        t.sc_u = w[3:0];
        return t;
    endfunction

    function automatic logic [TIME_W-1:0] time_to_word(input clk_time_s t);
        return {t.hr_t, t.hr_u, 1'b0, t.mn_t, t.mn_u, 1'b0, t.sc_t, t.sc_u};
    endfunction

    function automatic clk_date_s date_from_word(input logic [WORD_W-1:0] w);
        clk_date_s d;
        d.yr_t = w[23:20];
        d.yr_u = w[19:16];
        d.mo_t = w[12];
        d.mo_u = w[11:8];
        d.dy_t = w[5:4];
        d.dy_u = w[3:0];
        return d;
    endfunction

    function automatic logic [DATE_W-1:0] date_to_word(input clk_date_s d);
        return {d.yr_t, d.yr_u, 3'b000, d.mo_t, d.mo_u, 2'b00, d.dy_t, d.dy_u};
    endfunction

    function automatic logic is_leap(input logic [3:0] yt, input logic [3:0] yu);
        if (yt[0]) return (yu == 4'd2) || (yu == 4'd6);
        return (yu == 4'd0) || (yu == 4'd4) || (yu == 4'd8);
    endfunction

    // last day of month as two BCD digits {tens[1:0], units[3:0]}
    function automatic logic [5:0] last_day(input logic mt, input logic [3:0] mu, input logic leap);
        if (!mt && mu == 4'd2) return leap ? 6'h29 : 6'h28;
        if ((!mt && (mu == 4'd4 || mu == 4'd6 || mu == 4'd9)) || (mt && mu == 4'd1)) return 6'h30;
        return 6'h31;
    endfunction
endpackage

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  clk_time_s load_val,
    input  logic      h24,
    output clk_time_s cur,
    output logic      day_carry
);
    clk_time_s nxt;
    logic      c_sec, c_min, wrap;

    always_comb begin
        nxt   = cur;
        c_sec = 1'b0;
        c_min = 1'b0;
        wrap  = 1'b0;
        if (cur.sc_u == 4'd9) begin
            nxt.sc_u = 4'd0;
            if (cur.sc_t == 3'd5) begin
                nxt.sc_t = 3'd0;
                c_sec    = 1'b1;
            end else begin
                nxt.sc_t = cur.sc_t + 3'd1;
            end
        end else begin
            nxt.sc_u = cur.sc_u + 4'd1;
        end
        if (c_sec) begin
            if (cur.mn_u == 4'd9) begin
                nxt.mn_u = 4'd0;
                if (cur.mn_t == 3'd5) begin
                    nxt.mn_t = 3'd0;
                    c_min    = 1'b1;
                end else begin
                    nxt.mn_t = cur.mn_t + 3'd1;
                end
            end else begin
                nxt.mn_u = cur.mn_u + 4'd1;
            end
        end
        if (c_min) begin
            if (h24) begin
                if (cur.hr_t == 2'd2 && cur.hr_u == 4'd3) begin
                    nxt.hr_t = 2'd0;
                    nxt.hr_u = 4'd0;
                    wrap     = 1'b1;
                end else if (cur.hr_u == 4'd9) begin
                    nxt.hr_u = 4'd0;
                    nxt.hr_t = cur.hr_t + 2'd1;
                end else begin
                    nxt.hr_u = cur.hr_u + 4'd1;
                end
            end else begin
                // hr_t[1] carries PM, hr_t[0] is the hour tens digit
                if (cur.hr_t[0] && cur.hr_u == 4'd2) begin
                    nxt.hr_t[0] = 1'b0;
                    nxt.hr_u    = 4'd1;
                end else if (cur.hr_t[0] && cur.hr_u == 4'd1) begin
                    nxt.hr_u    = 4'd2;
                    nxt.hr_t[1] = ~cur.hr_t[1];
                    wrap        = cur.hr_t[1];
                end else if (cur.hr_u == 4'd9) begin
                    nxt.hr_t[0] = 1'b1;
                    nxt.hr_u    = 4'd0;
                end else begin
                    nxt.hr_u = cur.hr_u + 4'd1;
                end
            end
        end
    end

    assign day_carry = tick && !load && wrap;

    always_ff @(posedge clk) begin
        if (rst)       cur <= '0;
        else if (load) cur <= load_val;
        else if (tick) cur <= nxt;
    end
endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              day_inc,
    input  logic              load_date,
    input  clk_date_s         date_val,
    input  logic              load_wday,
    input  logic [WDAY_W-1:0] wday_val,
    output clk_date_s         cur,
    output logic [WDAY_W-1:0] wday,
    output logic              leap
);
    clk_date_s  nxt;
    logic [5:0] last;

    assign leap = is_leap(cur.yr_t, cur.yr_u);
    assign last = last_day(cur.mo_t, cur.mo_u, leap);

    always_comb begin
        nxt = cur;
        if ({cur.dy_t, cur.dy_u} == last) begin
            nxt.dy_t = 2'd0;
            nxt.dy_u = 4'd1;
            if (cur.mo_t && cur.mo_u == 4'd2) begin
                nxt.mo_t = 1'b0;
                nxt.mo_u = 4'd1;
                if (cur.yr_u == 4'd9) begin
                    nxt.yr_u = 4'd0;
                    nxt.yr_t = (cur.yr_t == 4'd9) ? 4'd0 : cur.yr_t + 4'd1;
                end else begin
                    nxt.yr_u = cur.yr_u + 4'd1;
                end
            end else if (cur.mo_u == 4'd9) begin
                nxt.mo_t = 1'b1;
                nxt.mo_u = 4'd0;
            end else begin
                nxt.mo_u = cur.mo_u + 4'd1;
            end
        end else if (cur.dy_u == 4'd9) begin
            nxt.dy_u = 4'd0;
            nxt.dy_t = cur.dy_t + 2'd1;
        end else begin
            nxt.dy_u = cur.dy_u + 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '{yr_t: 4'd0, yr_u: 4'd0, mo_t: 1'b0, mo_u: 4'd1, dy_t: 2'd0, dy_u: 4'd1};
            wday <= WD_RESET;
        end else begin
            if (load_date)    cur <= date_val;
            else if (day_inc) cur <= nxt;
            if (load_wday)    wday <= wday_val;
            else if (day_inc) wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
(
    input  clk_time_s        t_cur,
    input  clk_date_s        d_cur,
    input  clk_time_s        t_alm,
    input  clk_date_s        d_alm,
    input  logic [DIG_N-1:0] t_mask,
    input  logic [DIG_N-1:0] d_mask,
    input  logic             h24,
    output logic             match
);
    localparam int ALL_N = 2 * DIG_N;
    logic [ALL_N-1:0] eq, msk, hit;

    assign eq = {d_cur.yr_t == d_alm.yr_t, d_cur.yr_u == d_alm.yr_u,
                 d_cur.mo_t == d_alm.mo_t, d_cur.mo_u == d_alm.mo_u,
                 d_cur.dy_t == d_alm.dy_t, d_cur.dy_u == d_alm.dy_u,
                 t_cur.hr_t == t_alm.hr_t, t_cur.hr_u == t_alm.hr_u,
                 t_cur.mn_t == t_alm.mn_t, t_cur.mn_u == t_alm.mn_u,
                 t_cur.sc_t == t_alm.sc_t, t_cur.sc_u == t_alm.sc_u};

    // hour masks only count in 24-hour format
    assign msk = {d_mask, t_mask[5:4] & {2{h24}}, t_mask[3:0]};

    genvar i;
    generate
        for (i = 0; i < ALL_N; i++) begin : g_dig
            assign hit[i] = eq[i] | msk[i];
        end
    endgenerate

    assign match = &hit;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [TIME_W-1:0] time_o,
    output logic [DATE_W-1:0] date_o,
    output logic [WDAY_W-1:0] weekday_o,
    output logic              leap_o,
    output logic              alarm_flag_o,
    output logic              irq_o
);
    clk_time_s        t_cur, t_alm;
    clk_date_s        d_cur, d_alm;
    logic [DIG_N-1:0] t_mask, d_mask;
    logic             h24, alm_en, pend, flag, match, day_carry;
    logic             wr_time, wr_date, wr_wday, clr;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[15], wr_data[7]};
    assign wr_time = wr_en && (wr_addr == A_TIME);
    assign wr_date = wr_en && (wr_addr == A_DATE);
    assign wr_wday = wr_en && (wr_addr == A_WDAY);
    assign clr     = wr_en && (wr_addr == A_ACLR) && wr_data[0];

    rtc_time_cnt u_time (
        .clk(clk), .rst(rst), .tick(sec_tick), .load(wr_time),
        .load_val(time_from_word(wr_data)), .h24(h24),
        .cur(t_cur), .day_carry(day_carry)
    );

    rtc_date_cnt u_date (
        .clk(clk), .rst(rst), .day_inc(day_carry),
        .load_date(wr_date), .date_val(date_from_word(wr_data)),
        .load_wday(wr_wday), .wday_val(wr_data[WDAY_W-1:0]),
        .cur(d_cur), .wday(weekday_o), .leap(leap_o)
    );

    rtc_alarm_cmp u_cmp (
        .t_cur(t_cur), .d_cur(d_cur), .t_alm(t_alm), .d_alm(d_alm),
        .t_mask(t_mask), .d_mask(d_mask), .h24(h24), .match(match)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            h24    <= 1'b1;
            t_alm  <= '0;
            d_alm  <= '0;
            t_mask <= '0;
            d_mask <= '0;
            alm_en <= 1'b0;
            pend   <= 1'b0;
            flag   <= 1'b0;
        end else begin
            pend <= sec_tick;
            if (pend && match) flag <= 1'b1;
            else if (clr)      flag <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    A_MODE:  h24    <= wr_data[0];
                    A_ATIME: t_alm  <= time_from_word(wr_data);
                    A_ADATE: d_alm  <= date_from_word(wr_data);
                    A_TMASK: t_mask <= wr_data[DIG_N-1:0];
                    A_DMASK: d_mask <= wr_data[DIG_N-1:0];
                    A_AEN:   alm_en <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    assign time_o       = time_to_word(t_cur);
    assign date_o       = date_to_word(d_cur);
    assign alarm_flag_o = flag;
    assign irq_o        = flag & alm_en;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              clr_bit,
    input logic [TIME_W-1:0] time_o,
    input logic [DATE_W-1:0] date_o,
    input logic [WDAY_W-1:0] weekday_o,
    input logic              alarm_flag_o,
    input logic              irq_o
);
    AST_SEC_UNITS_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(sec_tick) && !$past(wr_en) && $past(time_o[3:0]) == 4'd9) |-> (time_o[3:0] == 4'd0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(sec_tick) && !$past(wr_en)) |-> ($stable(time_o) && $stable(date_o))); // R2

    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(weekday_o) == 3'd6 && weekday_o != 3'd6 && !$past(wr_en)) |-> (weekday_o == 3'd0)); // R7

    AST_FLAG_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag_o) |-> $past(sec_tick, 2)); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> alarm_flag_o); // R10

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && wr_addr == A_ACLR && clr_bit) && !$past(sec_tick, 2)) |-> !alarm_flag_o); // R10
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .clr_bit(wr_data[0]), .time_o(time_o), .date_o(date_o), .weekday_o(weekday_o),
    .alarm_flag_o(alarm_flag_o), .irq_o(irq_o)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        sec_tick = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_addr = 0;
    logic [23:0] wr_data = 0;
    logic [21:0] time_o;
    logic [23:0] date_o;
    logic [2:0]  weekday_o;
    logic        leap_o, alarm_flag_o, irq_o;

    always #10 clk = ~clk;

    rtc_calendar u_rtc_calendar (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .time_o(time_o), .date_o(date_o), .weekday_o(weekday_o),
        .leap_o(leap_o), .alarm_flag_o(alarm_flag_o), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    string req = "R11";

    // reference model state
    int  m_s, m_mn, m_h, m_pm, m_d, m_mo, m_y, m_wd;
    bit  m_h24, m_en, m_flag, m_pend;
    int  m_atime, m_adate, m_tmask, m_dmask;

    function automatic int fld(int w, int lo, int wd);
        return (w >> lo) & ((1 << wd) - 1);
    endfunction

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int tword(bit h24, int h, int pm, int mn, int s);
        int ht;
        ht = h24 ? h / 10 : ((pm << 1) | (h / 10));
        return (ht << 20) | ((h % 10) << 16) | ((mn / 10) << 12) | ((mn % 10) << 8) | ((s / 10) << 4) | (s % 10);
    endfunction

    function automatic int dword(int y, int mo, int d);
        return ((y / 10) << 20) | ((y % 10) << 16) | ((mo / 10) << 12) | ((mo % 10) << 8) | ((d / 10) << 4) | (d % 10);
    endfunction

    function automatic bit m_match();
        int tw, dw;
        int tlo[6] = '{0, 4, 8, 12, 16, 20};
        int twd[6] = '{4, 3, 4, 3, 4, 2};
        int dlo[6] = '{0, 4, 8, 12, 16, 20};
        int dwd[6] = '{4, 2, 4, 1, 4, 4};
        tw = tword(m_h24, m_h, m_pm, m_mn, m_s);
        dw = dword(m_y, m_mo, m_d);
        for (int i = 0; i < 6; i++) begin
            bit mk;
            mk = m_tmask[i] && (i < 4 || m_h24);
            if (!mk && fld(tw, tlo[i], twd[i]) != fld(m_atime, tlo[i], twd[i])) return 0;
            if (!m_dmask[i] && fld(dw, dlo[i], dwd[i]) != fld(m_adate, dlo[i], dwd[i])) return 0;
        end
        return 1;
    endfunction

    task automatic m_day_inc();
        m_wd = (m_wd >= 6) ? 0 : m_wd + 1;
        if (m_d == mdays(m_mo, m_y)) begin
            m_d = 1;
            if (m_mo == 12) begin
                m_mo = 1;
                m_y = (m_y + 1) % 100;
            end else m_mo++;
        end else m_d++;
    endtask

    task automatic m_tick();
        bit carry = 0;
        m_s++;
        if (m_s == 60) begin
            m_s = 0;
            m_mn++;
            if (m_mn == 60) begin
                m_mn = 0;
                if (m_h24) begin
                    if (m_h == 23) begin m_h = 0; carry = 1; end
                    else m_h++;
                end else begin
                    if (m_h == 11) begin
                        m_h = 12;
                        m_pm = 1 - m_pm;
                        carry = (m_pm == 0);
                    end else if (m_h == 12) m_h = 1;
                    else m_h++;
                end
            end
        end
        if (carry) m_day_inc();
    endtask

    task automatic m_step(bit tk, bit we, int a, int d);
        bit nf;
        nf = m_flag;
        if (m_pend && m_match()) nf = 1;
        else if (we && a == 9 && d[0]) nf = 0;
        if (we) begin
            case (a)
                0: begin
                    m_s  = fld(d, 4, 3) * 10 + fld(d, 0, 4);
                    m_mn = fld(d, 12, 3) * 10 + fld(d, 8, 4);
                    if (m_h24) begin m_h = fld(d, 20, 2) * 10 + fld(d, 16, 4); m_pm = 0; end
                    else begin m_h = fld(d, 20, 1) * 10 + fld(d, 16, 4); m_pm = fld(d, 21, 1); end
                end
                1: begin
                    m_d  = fld(d, 4, 2) * 10 + fld(d, 0, 4);
                    m_mo = fld(d, 12, 1) * 10 + fld(d, 8, 4);
                    m_y  = fld(d, 20, 4) * 10 + fld(d, 16, 4);
                end
                2: m_wd = fld(d, 0, 3);
                3: m_h24 = d[0];
                4: m_atime = d;
                5: m_adate = d;
                6: m_tmask = fld(d, 0, 6);
                7: m_dmask = fld(d, 0, 6);
                8: m_en = d[0];
                default: ;
            endcase
        end else if (tk) m_tick();
        m_pend = tk;
        m_flag = nf;
    endtask

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("time", time_o, tword(m_h24, m_h, m_pm, m_mn, m_s));
        chk("date", date_o, dword(m_y, m_mo, m_d));
        chk("weekday", weekday_o, m_wd);
        chk("leap", leap_o, (m_y % 4 == 0));
        chk("flag", alarm_flag_o, m_flag);
        chk("irq", irq_o, m_flag && m_en);
    endtask

    task automatic cyc(bit tk, bit we, int a, int d);
        sec_tick = tk;
        wr_en    = we;
        wr_addr  = a[3:0];
        wr_data  = d[23:0];
        @(posedge clk);
        m_step(tk, we, a, d);
        @(negedge clk);
        sec_tick = 0;
        wr_en    = 0;
        compare_all();
    endtask

    task automatic wr(int a, int d);
        cyc(0, 1, a, d);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 0, 0);
            cyc(0, 0, 0, 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        m_s = 0; m_mn = 0; m_h = 0; m_pm = 0; m_d = 1; m_mo = 1; m_y = 0; m_wd = 6;
        m_h24 = 1; m_en = 0; m_flag = 0; m_pend = 0;
        m_atime = 0; m_adate = 0; m_tmask = 0; m_dmask = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        req = "R11";
        compare_all();

        req = "R2";
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

        req = "R1";
        wr(0, tword(1, 10, 0, 58, 55));
        ticks(8);

        req = "R3";
        wr(1, dword(99, 12, 31));
        wr(2, 5);
        wr(0, tword(1, 23, 0, 59, 57));
        ticks(5);
        wr(0, tword(1, 9, 0, 59, 59));
        ticks(2);

        req = "R5";
        for (int yy = 23; yy <= 24; yy++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                wr(1, dword(yy, mo, mdays(mo, yy) - 1));
                wr(0, tword(1, 23, 0, 59, 59));
                ticks(1);
                req = "R6";
                wr(0, tword(1, 23, 0, 59, 59));
                ticks(1);
                req = "R5";
            end
        end

        req = "R7";
        wr(2, 7);
        wr(0, tword(1, 23, 0, 59, 59));
        ticks(1);
        wr(2, 6);
        wr(0, tword(1, 23, 0, 59, 59));
        ticks(1);

        req = "R4";
        wr(3, 0);
        wr(0, tword(0, 11, 0, 59, 58));
        ticks(3);
        wr(0, tword(0, 12, 1, 59, 59));
        ticks(2);
        wr(0, tword(0, 9, 1, 59, 59));
        ticks(1);
        wr(0, tword(0, 11, 1, 59, 58));
        ticks(3);

        req = "R8";
        wr(3, 1);
        wr(1, dword(30, 6, 15));
        wr(4, tword(1, 10, 0, 0, 5));
        wr(5, dword(30, 6, 15));
        wr(8, 1);
        wr(0, tword(1, 10, 0, 0, 0));
        ticks(7);
        req = "R10";
        wr(9, 1);
        cyc(0, 0, 0, 0);
        wr(8, 0);
        req = "R8";
        wr(6, 3);
        ticks(3);
        wr(9, 1);
        ticks(2);
        wr(9, 1);
        wr(5, dword(31, 7, 16));
        ticks(3);
        wr(7, 6'h3f);
        ticks(2);
        req = "R10";
        wr(8, 1);
        cyc(0, 0, 0, 0);
        wr(9, 1);
        cyc(1, 0, 0, 0);
        cyc(0, 1, 9, 1);
        cyc(0, 0, 0, 0);

        req = "R9";
        wr(9, 1);
        wr(4, tword(1, 5, 0, 0, 5));
        wr(6, 6'h30);
        wr(0, tword(1, 10, 0, 0, 4));
        ticks(2);
        wr(9, 1);
        wr(3, 0);
        wr(0, tword(0, 10, 0, 0, 4));
        ticks(2);
        wr(4, tword(0, 10, 1, 0, 5));
        wr(0, tword(0, 10, 0, 0, 4));
        ticks(2);
        wr(0, tword(0, 10, 1, 0, 4));
        ticks(2);

        summary();
    end
endmodule